// File: doc/BRIEF.md
# E1 Timeslot-0 Spare Bit Capture

This block sits behind an E1 receive framer and keeps a host-readable copy of the service bits carried in timeslot 0. The framer supplies a serial data bit, a bit-clock enable, a marker on the first bit of every 256-bit frame and a marker on the first bit of every 16-frame multiframe. The block counts frame and bit positions from those markers. It does not search for alignment and does not check CRC.

Two snapshot sets are kept. The short set holds the whole timeslot-0 octet of an align frame and of the following non-align frame, and is refreshed once per double-frame (250 us). The long set holds eight column registers gathered over a full multiframe: the Si bit of each align frame, the Si bit of each non-align frame, the remote-alarm bit, and the five spare bits Sa4 to Sa8. Bits are shifted into working registers as they arrive. They are copied to the host-visible registers in a single step at the boundary, so the host sees a consistent set for one full period. Each set has its own sticky flag, which the host clears by pulsing a write-one-to-clear input.

Top module: `e1ts0_capture`

## Requirements
- R1: During and right after reset, every snapshot output and both flags are zero.
- R2: Nothing is captured and no flag rises until the first multiframe marker. Frame 0 of a multiframe is an align frame, and frames alternate align and non-align after it.
- R3: `af_octet` and `naf_octet` hold the timeslot-0 octets (bit positions 0..7 of the frame) of the last align frame and the non-align frame that follows it, exactly as received. The first received bit is at bit 7.
- R4: The double-frame snapshot is updated on the first bit of an align frame, and only when an align and a non-align timeslot 0 have been gathered since the last update. Between updates it stays unchanged.
- R5: Each double-frame update sets `df_flag`. The flag stays set until a cycle with `clr_df` high and no update in that cycle clears it. An update in the same cycle as a clear leaves the flag set.
- R6: Column k of a multiframe register holds, at bit 7-k, the bit from double-frame k (frames 2k and 2k+1). `si_align` takes octet bit 7 of frame 2k. `si_nonalign` takes octet bit 7 of frame 2k+1. `alarm_bits` takes octet bit 5 of frame 2k+1. `saN_bits` (N = 4..8) takes octet bit 8-N of frame 2k+1.
- R7: All eight multiframe registers are updated together on the multiframe marker that follows a complete 16-frame multiframe. Otherwise they are unchanged.
- R8: Each multiframe update sets `mf_flag`. It uses the same sticky, clear and set-wins behaviour as `df_flag`, driven by `clr_mf`.
- R9: In cycles with `bit_en` low, `rx_bit`, `frame_start` and `mf_start` are ignored.
- R10: A multiframe marker that arrives before frame 15's timeslot 0 is complete causes no multiframe update. The partial data is dropped and counting restarts at frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies one received bit per high cycle |
| rx_bit | input | 1 | Received serial data bit |
| frame_start | input | 1 | Marks bit 0 of a frame (with bit_en) |
| mf_start | input | 1 | Marks bit 0 of frame 0 of a multiframe (with bit_en) |
| clr_df | input | 1 | Write-one-to-clear pulse for df_flag |
| clr_mf | input | 1 | Write-one-to-clear pulse for mf_flag |
| af_octet | output | 8 | Timeslot-0 octet of the last align frame |
| naf_octet | output | 8 | Timeslot-0 octet of the last non-align frame |
| si_align | output | 8 | Si bits of the align frames of one multiframe |
| si_nonalign | output | 8 | Si bits of the non-align frames of one multiframe |
| alarm_bits | output | 8 | Remote-alarm bits of one multiframe |
| sa4_bits | output | 8 | Sa4 bits of one multiframe |
| sa5_bits | output | 8 | Sa5 bits of one multiframe |
| sa6_bits | output | 8 | Sa6 bits of one multiframe |
| sa7_bits | output | 8 | Sa7 bits of one multiframe |
| sa8_bits | output | 8 | Sa8 bits of one multiframe |
| df_flag | output | 1 | Sticky double-frame update flag |
| mf_flag | output | 1 | Sticky multiframe update flag |

## Verification
The assertions watch the update discipline on every cycle. Each snapshot set changes only in a cycle with an update. Every update sets its flag, and a flag rises only after an update. A clear without an update drops the flag. No update happens while the bit enable is low, and a multiframe update happens only on a qualified marker. The bench scenarios show what depends on stream content and history: the exact octet and column bit placement, the wait for a complete align/non-align pair, the first-marker start, the dropping of a truncated multiframe, and the handling of spurious markers and data during enable gaps.

// File: rtl/e1ts0_pkg.sv
package e1ts0_pkg;
  localparam int OCT_W = 8;
  localparam int NCOL  = 8;

  localparam logic [2:0] COL_SI_AF  = 3'd0;
  localparam logic [2:0] COL_SI_NAF = 3'd1;

  typedef struct packed {
    logic       hit;
    logic [2:0] idx;
  } col_sel_t;

  // Column that a timeslot-0 bit feeds: align frames give only Si,
  // non-align frames give Si, alarm and Sa4..Sa8 (column = bit position).
  function automatic col_sel_t col_of(input logic odd_frame, input logic [2:0] pos);
    col_sel_t r;
    r.hit = 1'b0;
    r.idx = 3'd0;
    if (!odd_frame) begin
      if (pos == 3'd0) begin
        r.hit = 1'b1;
        r.idx = COL_SI_AF;
      end
    end else if (pos == 3'd0) begin
      r.hit = 1'b1;
      r.idx = COL_SI_NAF;
    end else if (pos >= 3'd2) begin
      r.hit = 1'b1;
      r.idx = pos;
    end
    return r;
  endfunction

  function automatic logic [OCT_W-1:0] shift_in(input logic [OCT_W-1:0] v, input logic b);
    return {v[OCT_W-2:0], b};
  endfunction
endpackage

// File: rtl/e1ts0_pos_track.sv
module e1ts0_pos_track #(
  parameter int FRAME_BITS = 256,
  parameter int MF_FRAMES  = 16,
  localparam int BW = $clog2(FRAME_BITS),
  localparam int FW = $clog2(MF_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          frame_start,
  input  logic          mf_start,
  output logic [BW-1:0] cur_pos,
  output logic [FW-1:0] cur_frame,
  output logic          live
);
  logic [BW-1:0] bit_q;
  logic [FW-1:0] frm_q;
  logic          sync_q;
  logic [FW-1:0] frm_inc;
  logic [FW-1:0] cur_inc;

  assign frm_inc = (frm_q == FW'(MF_FRAMES-1)) ? '0 : frm_q + 1'b1;
  assign cur_inc = (cur_frame == FW'(MF_FRAMES-1)) ? '0 : cur_frame + 1'b1;
  assign live    = sync_q | mf_start;

  always_comb begin
    if (mf_start) begin
      cur_pos   = '0;
      cur_frame = '0;
    end else if (frame_start) begin
      cur_pos   = '0;
      cur_frame = (bit_q == '0) ? frm_q : frm_inc;
    end else begin
      cur_pos   = bit_q;
      cur_frame = frm_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q  <= '0;
      frm_q  <= '0;
      sync_q <= 1'b0;
    end else if (bit_en) begin
      sync_q <= sync_q | mf_start;
      if (cur_pos == BW'(FRAME_BITS-1)) begin
        bit_q <= '0;
        frm_q <= cur_inc;
      end else begin
        bit_q <= cur_pos + 1'b1;
        frm_q <= cur_frame;
      end
    end
  end
endmodule

// File: rtl/e1ts0_df_snap.sv
module e1ts0_df_snap
  import e1ts0_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rx_bit,
  input  logic             in_ts0,
  input  logic [2:0]       pos3,
  input  logic             odd,
  output logic [OCT_W-1:0] af_o,
  output logic [OCT_W-1:0] naf_o,
  output logic             commit_o
);
  logic [OCT_W-1:0] af_work, naf_work;
  logic             pair_q;
  logic             ts_tick, align_first, naf_last;

  assign ts_tick     = tick & in_ts0;
  assign align_first = ts_tick & ~odd & (pos3 == 3'd0);
  assign naf_last    = ts_tick & odd & (pos3 == 3'd7);
  assign commit_o    = align_first & pair_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      af_work  <= '0;
      naf_work <= '0;
      pair_q   <= 1'b0;
      af_o     <= '0;
      naf_o    <= '0;
    end else begin
      if (ts_tick && !odd) af_work  <= shift_in(af_work, rx_bit);
      if (ts_tick && odd)  naf_work <= shift_in(naf_work, rx_bit);
      if (align_first)     pair_q   <= 1'b0;
      else if (naf_last)   pair_q   <= 1'b1;
      if (commit_o) begin
        af_o  <= af_work;
        naf_o <= naf_work;
      end
    end
  end
endmodule

// File: rtl/e1ts0_mf_cols.sv
module e1ts0_mf_cols
  import e1ts0_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       rx_bit,
  input  logic                       in_ts0,
  input  logic [2:0]                 pos3,
  input  logic                       odd,
  input  logic                       mf_mark,
  input  logic                       last_bit,
  output logic [NCOL-1:0][COL_W-1:0] cols_o,
  output logic                       commit_o
);
  col_sel_t sel;
  logic     ready_q;

  assign sel      = col_of(odd, pos3);
  assign commit_o = mf_mark & ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        ready_q <= 1'b0;
    else if (mf_mark)  ready_q <= 1'b0;
    else if (last_bit) ready_q <= 1'b1;
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [COL_W-1:0] work_q, host_q;
    logic             take;
    assign take = tick & in_ts0 & sel.hit & (sel.idx == 3'(c));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        work_q <= '0;
        host_q <= '0;
      end else begin
        if (take)     work_q <= {work_q[COL_W-2:0], rx_bit};
        if (commit_o) host_q <= work_q;
      end
    end
    assign cols_o[c] = host_q;
  end
endmodule

// File: rtl/e1ts0_sticky.sv
module e1ts0_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= set_i | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/e1ts0_capture.sv
module e1ts0_capture
  import e1ts0_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int MF_FRAMES  = 16,
  localparam int BW    = $clog2(FRAME_BITS),
  localparam int FW    = $clog2(MF_FRAMES),
  localparam int COL_W = MF_FRAMES / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             rx_bit,
  input  logic             frame_start,
  input  logic             mf_start,
  input  logic             clr_df,
  input  logic             clr_mf,
  output logic [OCT_W-1:0] af_octet,
  output logic [OCT_W-1:0] naf_octet,
  output logic [COL_W-1:0] si_align,
  output logic [COL_W-1:0] si_nonalign,
  output logic [COL_W-1:0] alarm_bits,
  output logic [COL_W-1:0] sa4_bits,
  output logic [COL_W-1:0] sa5_bits,
  output logic [COL_W-1:0] sa6_bits,
  output logic [COL_W-1:0] sa7_bits,
  output logic [COL_W-1:0] sa8_bits,
  output logic             df_flag,
  output logic             mf_flag
);
  logic [BW-1:0]               cur_pos;
  logic [FW-1:0]               cur_frame;
  logic                        live, tick, in_ts0, odd, mf_mark, last_bit;
  logic [2:0]                  pos3;
  logic                        df_commit, mf_commit;
  logic [NCOL-1:0][COL_W-1:0]  mf_cols;

  e1ts0_pos_track #(.FRAME_BITS(FRAME_BITS), .MF_FRAMES(MF_FRAMES)) pos_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .mf_start(mf_start), .cur_pos(cur_pos), .cur_frame(cur_frame), .live(live)
  );

  assign tick     = bit_en & live;
  assign in_ts0   = (cur_pos < BW'(OCT_W));
  assign pos3     = cur_pos[2:0];
  assign odd      = cur_frame[0];
  assign mf_mark  = bit_en & mf_start;
  assign last_bit = tick & in_ts0 & (pos3 == 3'd7) & (cur_frame == FW'(MF_FRAMES-1));

  e1ts0_df_snap df_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_bit(rx_bit), .in_ts0(in_ts0),
    .pos3(pos3), .odd(odd), .af_o(af_octet), .naf_o(naf_octet), .commit_o(df_commit)
  );

  e1ts0_mf_cols #(.COL_W(COL_W)) mf_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_bit(rx_bit), .in_ts0(in_ts0),
    .pos3(pos3), .odd(odd), .mf_mark(mf_mark), .last_bit(last_bit),
    .cols_o(mf_cols), .commit_o(mf_commit)
  );

  e1ts0_sticky df_flag_i (.clk(clk), .rst_n(rst_n), .set_i(df_commit), .clr_i(clr_df), .flag_o(df_flag));
  e1ts0_sticky mf_flag_i (.clk(clk), .rst_n(rst_n), .set_i(mf_commit), .clr_i(clr_mf), .flag_o(mf_flag));

  assign si_align    = mf_cols[0];
  assign si_nonalign = mf_cols[1];
  assign alarm_bits  = mf_cols[2];
  assign sa4_bits    = mf_cols[3];
  assign sa5_bits    = mf_cols[4];
  assign sa6_bits    = mf_cols[5];
  assign sa7_bits    = mf_cols[6];
  assign sa8_bits    = mf_cols[7];
endmodule

// File: rtl/e1ts0_capture_chk.sv
module e1ts0_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bit_en,
  input logic        mf_start,
  input logic        clr_df,
  input logic        clr_mf,
  input logic        df_commit,
  input logic        mf_commit,
  input logic        df_flag,
  input logic        mf_flag,
  input logic [7:0]  af_octet,
  input logic [7:0]  naf_octet,
  input logic [63:0] mf_bus
);
  // R4
  df_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !df_commit |=> $stable({af_octet, naf_octet}));
  // R5
  df_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    df_commit |=> df_flag);
  // R5
  df_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_df && !df_commit) |=> !df_flag);
  // R5
  df_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(df_flag) |-> $past(df_commit));
  // R7
  mf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_commit |=> $stable(mf_bus));
  // R7
  mf_when_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_commit |-> (bit_en && mf_start));
  // R8
  mf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_commit |=> mf_flag);
  // R8
  mf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mf && !mf_commit) |=> !mf_flag);
  // R9
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |-> (!df_commit && !mf_commit));
endmodule

bind e1ts0_capture e1ts0_capture_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mf_start(mf_start),
  .clr_df(clr_df), .clr_mf(clr_mf), .df_commit(df_commit), .mf_commit(mf_commit),
  .df_flag(df_flag), .mf_flag(mf_flag), .af_octet(af_octet), .naf_octet(naf_octet),
  .mf_bus(mf_cols)
);

// File: tb/e1ts0_capture_tb.sv
module e1ts0_capture_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, rx_bit = 1'b0, frame_start = 1'b0, mf_start = 1'b0;
  logic clr_df = 1'b0, clr_mf = 1'b0;
  logic [7:0] af_octet, naf_octet, si_align, si_nonalign, alarm_bits;
  logic [7:0] sa4_bits, sa5_bits, sa6_bits, sa7_bits, sa8_bits;
  logic df_flag, mf_flag;

  always #5 clk = ~clk;

  e1ts0_capture dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .frame_start(frame_start), .mf_start(mf_start), .clr_df(clr_df), .clr_mf(clr_mf),
    .af_octet(af_octet), .naf_octet(naf_octet), .si_align(si_align),
    .si_nonalign(si_nonalign), .alarm_bits(alarm_bits), .sa4_bits(sa4_bits),
    .sa5_bits(sa5_bits), .sa6_bits(sa6_bits), .sa7_bits(sa7_bits), .sa8_bits(sa8_bits),
    .df_flag(df_flag), .mf_flag(mf_flag)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // bench model
  logic [7:0] m_af_host = '0, m_naf_host = '0, m_af_cur = '0, m_naf_cur = '0;
  bit         m_pair = 1'b0, m_mf_ready = 1'b0, m_mf_flag = 1'b0;
  logic [7:0] m_mf_host [8];
  logic [7:0] prev_blk [16];
  logic [7:0] cur_blk [16];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic noise();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  function automatic logic [7:0] ts0_of(input int seed, input int f);
    return 8'((seed * 37) + (f * 91) + (f * f * 13)) ^ 8'h5A;
  endfunction

  function automatic logic [7:0] dut_col(input int j);
    case (j)
      0: return si_align;
      1: return si_nonalign;
      2: return alarm_bits;
      3: return sa4_bits;
      4: return sa5_bits;
      5: return sa6_bits;
      6: return sa7_bits;
      default: return sa8_bits;
    endcase
  endfunction

  // One qualified bit, preceded by `gaps` unqualified cycles carrying junk.
  task automatic send_bit(input logic b, input logic fs, input logic ms, input int gaps,
                          input logic cd, input logic cm);
    for (int g = 0; g < gaps; g++) begin
      @(negedge clk);
      bit_en = 1'b0; rx_bit = noise(); frame_start = 1'b1; mf_start = noise();
    end
    @(negedge clk);
    bit_en = 1'b1; rx_bit = b; frame_start = fs; mf_start = ms; clr_df = cd; clr_mf = cm;
    @(negedge clk);
    bit_en = 1'b0; frame_start = 1'b0; mf_start = 1'b0; clr_df = 1'b0; clr_mf = 1'b0;
    rx_bit = noise();
  endtask

  task automatic pulse_clr(input logic cd, input logic cm);
    @(negedge clk);
    clr_df = cd; clr_mf = cm;
    @(negedge clk);
    clr_df = 1'b0; clr_mf = 1'b0;
  endtask

  task automatic check_df_boundary(input bit collide);
    if (m_pair) begin
      m_af_host = m_af_cur; m_naf_host = m_naf_cur; m_pair = 1'b0;
      chk(df_flag == 1'b1, collide ? "R5 set wins over clear" : "R5 df flag set", 64'(df_flag), 64'd1);
      chk(af_octet == m_af_host, "R3 align octet", 64'(af_octet), 64'(m_af_host));
      chk(naf_octet == m_naf_host, "R3 non-align octet", 64'(naf_octet), 64'(m_naf_host));
      pulse_clr(1'b1, 1'b0);
      chk(df_flag == 1'b0, "R5 df flag cleared", 64'(df_flag), 64'd0);
    end else begin
      chk(df_flag == 1'b0, "R4 no update without pair", 64'(df_flag), 64'd0);
      chk({af_octet, naf_octet} == {m_af_host, m_naf_host}, "R4 df held",
          64'({af_octet, naf_octet}), 64'({m_af_host, m_naf_host}));
    end
  endtask

  task automatic check_mf_boundary();
    if (m_mf_ready) begin
      for (int k = 0; k < 8; k++) begin
        m_mf_host[0][7-k] = prev_blk[2*k][7];
        m_mf_host[1][7-k] = prev_blk[2*k+1][7];
        for (int j = 2; j < 8; j++) m_mf_host[j][7-k] = prev_blk[2*k+1][7-j];
      end
      m_mf_flag = 1'b1;
      chk(mf_flag == 1'b1, "R8 mf flag set", 64'(mf_flag), 64'd1);
      for (int j = 0; j < 8; j++)
        chk(dut_col(j) == m_mf_host[j], "R6 column content", 64'(dut_col(j)), 64'(m_mf_host[j]));
    end else begin
      chk(mf_flag == m_mf_flag, "R10 no mf update", 64'(mf_flag), 64'(m_mf_flag));
      for (int j = 0; j < 8; j++)
        chk(dut_col(j) == m_mf_host[j], "R7 mf held", 64'(dut_col(j)), 64'(m_mf_host[j]));
    end
    m_mf_ready = 1'b0;
  endtask

  // Sends nfr frames starting at a multiframe marker and checks every boundary.
  task automatic run_block(input int seed, input int nfr, input int gaps, input bit collide);
    for (int f = 0; f < nfr; f++) begin
      logic [7:0] t;
      t = ts0_of(seed, f);
      cur_blk[f] = t;
      for (int p = 0; p < 256; p++) begin
        logic b;
        b = (p < 8) ? t[7-p] : noise();
        send_bit(b, p == 0, (p == 0) && (f == 0), gaps, collide && f == 0 && p == 0,
                 collide && f == 0 && p == 0);
        if (p == 0 && f == 0) check_mf_boundary();
        if (p == 0 && f % 2 == 0) check_df_boundary(collide && f == 0);
        if (p == 0 && f == 8 && m_mf_flag) begin
          chk(mf_flag == 1'b1, "R8 mf flag sticky", 64'(mf_flag), 64'd1);
          pulse_clr(1'b0, 1'b1);
          m_mf_flag = 1'b0;
          chk(mf_flag == 1'b0, "R8 mf flag cleared", 64'(mf_flag), 64'd0);
        end
        if (p == 7) begin
          if (f % 2 == 0) m_af_cur = t;
          else begin m_naf_cur = t; m_pair = 1'b1; end
        end
      end
    end
    if (nfr == 16) begin
      for (int f = 0; f < 16; f++) prev_blk[f] = cur_blk[f];
      m_mf_ready = 1'b1;
    end else begin
      m_mf_ready = 1'b0;
    end
  endtask

  task automatic test_reset();
    chk({af_octet, naf_octet} == 16'h0, "R1 df regs reset", 64'({af_octet, naf_octet}), 64'd0);
    chk({si_align, si_nonalign, alarm_bits, sa4_bits, sa5_bits, sa6_bits, sa7_bits, sa8_bits} == 64'h0,
        "R1 mf regs reset",
        {si_align, si_nonalign, alarm_bits, sa4_bits, sa5_bits, sa6_bits, sa7_bits, sa8_bits}, 64'd0);
    chk({df_flag, mf_flag} == 2'b00, "R1 flags reset", 64'({df_flag, mf_flag}), 64'd0);
  endtask

  task automatic test_presync();
    for (int f = 0; f < 3; f++)
      for (int p = 0; p < 256; p++)
        send_bit((p < 8) ? 1'b1 : noise(), p == 0, 1'b0, 0, 1'b0, 1'b0);
    chk({df_flag, mf_flag} == 2'b00, "R2 no flag before marker", 64'({df_flag, mf_flag}), 64'd0);
    chk({af_octet, naf_octet} == 16'h0, "R2 no capture before marker",
        64'({af_octet, naf_octet}), 64'd0);
  endtask

  initial begin
    for (int j = 0; j < 8; j++) m_mf_host[j] = '0;
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_presync();
    run_block(11, 16, 0, 1'b0);  // R2 first multiframe: nothing committed at its marker
    run_block(23, 16, 2, 1'b0);  // R9 gaps with junk data and markers
    run_block(37, 6, 0, 1'b1);   // R5 R8 clear colliding with updates
    run_block(41, 16, 0, 1'b0);  // R10 marker after truncated multiframe
    run_block(53, 16, 0, 1'b0);  // R7 R6 normal multiframe
    run_block(67, 2, 0, 1'b0);   // final marker commits the last full multiframe
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule